// File: doc/BRIEF.md
# Local-History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken using two table lookups. At fetch, low bits of the program counter select an entry in a per-branch history table. Each entry is a shift register of the most recent outcomes of the branches that map to it. That history value then addresses a pattern table of 2-bit saturating counters. This pattern table is shared by all branches. The selected counter gives the predicted direction.

The history and counter values read at fetch leave the block alongside the prediction and travel down the pipeline with the instruction. When the branch resolves, the pipeline returns them together with the branch PC, the real outcome and a flag saying whether the instruction was a branch. From those carried values the block writes a shifted history back to the per-branch entry and an adjusted counter back to the pattern entry the prediction used. Lookups are combinational. A write made at a clock edge is visible to lookups from the next cycle on.

Top module: `lhp_predictor`

## Requirements
- R1: The per-branch history entry is chosen by PC bits [IDX_W+1:2]. Two PCs that agree in those bits share one HIST_W-bit history, whatever their other bits are.
- R2: `pr_taken` is 1 exactly when the selected counter holds 2 or 3.
- R3: The pattern table is addressed by the local history value alone. Two branches whose histories are equal read and train the same counter.
- R4: On a branch resolve, the history entry for `rs_pc` becomes `{rs_hist[HIST_W-2:0], rs_taken}`. A 1 bit means taken and a 0 bit means not taken, and the newest outcome sits in bit 0.
- R5: On a branch resolve, the counter is computed from the carried value `rs_ctr`. It goes up by one on taken and down by one on not taken. It stays at 3 on taken and at 0 on not taken.
- R6: The pattern table write goes to address `rs_hist`, the carried history, and not to whatever the history entry holds at resolve time.
- R7: When `rs_is_branch` is 0, neither table changes.
- R8: After reset, every history entry and every counter is zero, so the first lookup predicts not taken with history 0.
- R9: `pr_hist` and `pr_ctr` are the values stored for `fe_pc` in the current cycle, given so that they can be carried to resolve.
- R10: A branch that repeats taken, taken, taken, not taken predicts every outcome correctly once it has trained, when HIST_W is 3 or more.
- R11: A resolve written at a clock edge is seen by a lookup in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_pc | input | PC_W | PC being fetched |
| pr_taken | output | 1 | Predicted direction, 1 = taken |
| pr_hist | output | HIST_W | Local history used for the prediction, to carry |
| pr_ctr | output | 2 | Counter value used for the prediction, to carry |
| rs_is_branch | input | 1 | Resolving instruction is a conditional branch |
| rs_pc | input | PC_W | PC of the resolving instruction |
| rs_taken | input | 1 | Resolved outcome, 1 = taken |
| rs_hist | input | HIST_W | Carried pre-resolve local history |
| rs_ctr | input | 2 | Carried pre-resolve counter |

## Verification
On every cycle, the assertions check the reset contents. They also check the one-cycle write-to-read path of both tables: a history shifted in from a resolve appears at a fetch of the same index, and a counter stepped from its carried value appears at a fetch whose history is the carried one. They also check that lookups stay stable when there is no branch resolve and the fetch PC is held. Aliasing across upper PC bits, counter sharing between different branches, and the use of stale carried values need set-up sequences, so only the bench scenarios show them. The same holds for the steady-state accuracy on a repeating loop pattern. All of these are compared against a behavioural model on every clock.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

   typedef logic [1:0] ctr_t;

   // one saturating step of a 2-bit direction counter
   function automatic ctr_t ctr_step(input ctr_t c, input logic up);
      ctr_t r;
      if (up) r = (c == 2'b11) ? c : c + 2'd1;
      else    r = (c == 2'b00) ? c : c - 2'd1;
      return r;
   endfunction

endpackage

// File: rtl/lhp_index.sv
module lhp_index #(
   parameter int PC_W  = 32,
   parameter int IDX_W = 6
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);
   logic unused_pc_bits;

   // word-aligned PC: skip the two alignment bits
   assign idx = pc[IDX_W+1:2];
   assign unused_pc_bits = ^{pc[PC_W-1:IDX_W+2], pc[1:0]};
endmodule

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
   parameter int IDX_W  = 6,
   parameter int HIST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [HIST_W-1:0] wr_old_hist,
   input  logic              wr_taken
);
   localparam int ENTRIES = 1 << IDX_W;

   logic [HIST_W-1:0] hist_q [ENTRIES];
   logic [HIST_W-1:0] hist_new;

   generate
      if (HIST_W == 1) begin : g_single
         logic unused_old;
         assign hist_new   = wr_taken;
         assign unused_old = wr_old_hist[0];
      end else begin : g_shift
         logic unused_msb;
         assign hist_new   = {wr_old_hist[HIST_W-2:0], wr_taken};
         assign unused_msb = wr_old_hist[HIST_W-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) hist_q[i] <= '0;
      end else if (wr_en) begin
         hist_q[wr_idx] <= hist_new;
      end
   end

   assign rd_hist = hist_q[rd_idx];
endmodule

// File: rtl/lhp_pattern_table.sv
module lhp_pattern_table
   import lhp_pkg::*;
#(
   parameter int HIST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HIST_W-1:0] rd_addr,
   output ctr_t              rd_ctr,
   input  logic              wr_en,
   input  logic [HIST_W-1:0] wr_addr,
   input  ctr_t              wr_old_ctr,
   input  logic              wr_taken
);
   localparam int ENTRIES = 1 << HIST_W;

   ctr_t ctr_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'b00;
      end else if (wr_en) begin
         ctr_q[wr_addr] <= ctr_step(wr_old_ctr, wr_taken);
      end
   end

   assign rd_ctr = ctr_q[rd_addr];
endmodule

// File: rtl/lhp_predictor.sv
module lhp_predictor #(
   parameter int PC_W   = 32,
   parameter int IDX_W  = 6,
   parameter int HIST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   fe_pc,
   output logic              pr_taken,
   output logic [HIST_W-1:0] pr_hist,
   output logic [1:0]        pr_ctr,
   input  logic              rs_is_branch,
   input  logic [PC_W-1:0]   rs_pc,
   input  logic              rs_taken,
   input  logic [HIST_W-1:0] rs_hist,
   input  logic [1:0]        rs_ctr
);
   generate
      if (HIST_W < 1 || HIST_W > 12) begin : g_bad_hist
         $error("HIST_W must be in 1..12");
      end
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("IDX_W must be in 1..12");
      end
      if (PC_W <= IDX_W + 2) begin : g_bad_pc
         $error("PC_W must exceed IDX_W+2");
      end
   endgenerate

   logic [IDX_W-1:0] fe_idx;
   logic [IDX_W-1:0] rs_idx;

   lhp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fe_index (
      .pc (fe_pc),
      .idx(fe_idx)
   );

   lhp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_rs_index (
      .pc (rs_pc),
      .idx(rs_idx)
   );

   lhp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     (fe_idx),
      .rd_hist    (pr_hist),
      .wr_en      (rs_is_branch),
      .wr_idx     (rs_idx),
      .wr_old_hist(rs_hist),
      .wr_taken   (rs_taken)
   );

   lhp_pattern_table #(.HIST_W(HIST_W)) u_pht (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr   (pr_hist),
      .rd_ctr    (pr_ctr),
      .wr_en     (rs_is_branch),
      .wr_addr   (rs_hist),
      .wr_old_ctr(rs_ctr),
      .wr_taken  (rs_taken)
   );

   // upper half of the counter range means taken
   assign pr_taken = pr_ctr[1];
endmodule

// File: rtl/lhp_checker.sv
module lhp_checker
   import lhp_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int HIST_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [IDX_W-1:0]  fe_idx,
   input logic [IDX_W-1:0]  rs_idx,
   input logic [HIST_W-1:0] pr_hist,
   input logic [1:0]        pr_ctr,
   input logic              rs_is_branch,
   input logic              rs_taken,
   input logic [HIST_W-1:0] rs_hist,
   input logic [1:0]        rs_ctr
);
   logic [HIST_W-1:0] shifted;
   assign shifted = HIST_W'({rs_hist, rs_taken});

   // R8: state right after reset is all zero
   a_r8_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pr_hist == '0 && pr_ctr == 2'b00));

   // R4, R11: a resolved history reaches the next fetch of that index
   a_r4_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
      rs_is_branch |=> (fe_idx != $past(rs_idx)) || (pr_hist == $past(shifted)));

   // R5, R6: counter stepped from the carried value lands at the carried history
   a_r5_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
      rs_is_branch |=> (pr_hist != $past(rs_hist))
                       || (pr_ctr == ctr_step($past(rs_ctr), $past(rs_taken))));

   // R7: no branch resolve and a held fetch index leaves the lookup unchanged
   a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_is_branch |=> !$stable(fe_idx) || ($stable(pr_hist) && $stable(pr_ctr)));
endmodule

bind lhp_predictor lhp_checker #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fe_idx      (fe_pc[IDX_W+1:2]),
   .rs_idx      (rs_pc[IDX_W+1:2]),
   .pr_hist     (pr_hist),
   .pr_ctr      (pr_ctr),
   .rs_is_branch(rs_is_branch),
   .rs_taken    (rs_taken),
   .rs_hist     (rs_hist),
   .rs_ctr      (rs_ctr)
);

// File: tb/lhp_predictor_bench.sv
`timescale 1ns/1ps
module lhp_predictor_bench;
   localparam int PW = 32;
   localparam int IW = 6;
   localparam int HW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] fe_pc = '0;
   logic          pr_taken;
   logic [HW-1:0] pr_hist;
   logic [1:0]    pr_ctr;
   logic          rs_is_branch = 1'b0;
   logic [PW-1:0] rs_pc = '0;
   logic          rs_taken = 1'b0;
   logic [HW-1:0] rs_hist = '0;
   logic [1:0]    rs_ctr = '0;

   always #5 clk = ~clk;

   lhp_predictor #(.PC_W(PW), .IDX_W(IW), .HIST_W(HW)) u_lhp_predictor (.*);

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // behavioural reference state
   int model_hist [int];
   int model_ctr  [int];
   int last_h, last_c, last_t;

   function automatic int idx_of(input logic [PW-1:0] pc);
      return (pc / 4) % (1 << IW);
   endfunction

   function automatic int get_h(input int i);
      return model_hist.exists(i) ? model_hist[i] : 0;
   endfunction

   function automatic int get_c(input int h);
      return model_ctr.exists(h) ? model_ctr[h] : 0;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic [PW-1:0] f, input logic b, input logic [PW-1:0] rp,
                       input logic rt, input int rh, input int rc);
      int eh, ec;
      @(negedge clk);
      fe_pc = f; rs_is_branch = b; rs_pc = rp; rs_taken = rt;
      rs_hist = HW'(rh); rs_ctr = 2'(rc);
      #1;
      eh = get_h(idx_of(f));
      ec = get_c(eh);
      check("R9 hist", int'(pr_hist), eh);
      check("R9 ctr", int'(pr_ctr), ec);
      check("R2 taken", int'(pr_taken), (ec >= 2) ? 1 : 0);
      last_h = int'(pr_hist); last_c = int'(pr_ctr); last_t = int'(pr_taken);
      @(posedge clk);
      if (rst_n && b) begin
         int nc;
         model_hist[idx_of(rp)] = ((rh * 2) + (rt ? 1 : 0)) % (1 << HW);
         nc = rt ? rc + 1 : rc - 1;
         if (nc > 3) nc = 3;
         if (nc < 0) nc = 0;
         model_ctr[rh] = nc;
      end
   endtask

   // fetch then resolve one branch with the values it carried
   task automatic run_branch(input logic [PW-1:0] pc, input logic outcome, output int hit);
      int h, c;
      step(pc, 1'b0, '0, 1'b0, 0, 0);
      h = last_h; c = last_c;
      hit = (last_t == int'(outcome)) ? 1 : 0;
      step(pc, 1'b1, pc, outcome, h, c);
   endtask

   initial begin
      int hit, miss;
      logic [PW-1:0] pa, pq, pl;
      pa = 32'h0000_0104; pq = 32'h0000_0208; pl = 32'h0000_0040;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R8: reset state
      step(32'h0000_0010, 1'b0, '0, 1'b0, 0, 0);
      check("R8 hist", last_h, 0);
      check("R8 ctr", last_c, 0);

      // R7: non-branch resolve writes nothing
      step(pa, 1'b0, pa, 1'b1, 5, 2);
      step(pa, 1'b0, '0, 1'b0, 0, 0);
      check("R7 hist", last_h, 0);
      check("R7 ctr", last_c, 0);

      // R5: counter at 0 stays 0 on not-taken
      for (int i = 0; i < 3; i++) run_branch(pq, 1'b0, hit);
      step(pq, 1'b0, '0, 1'b0, 0, 0);
      check("R5 floor", last_c, 0);

      // R4, R11: history shifts taken bits in at bit 0
      run_branch(pa, 1'b1, hit);
      step(pa, 1'b0, '0, 1'b0, 0, 0);
      check("R4 hist", last_h, 1);
      for (int i = 0; i < 10; i++) run_branch(pa, 1'b1, hit);
      step(pa, 1'b0, '0, 1'b0, 0, 0);
      check("R4 all taken", last_h, 15);
      check("R5 ceiling", last_c, 3);

      // R1: upper PC bits do not matter for the history index
      step(pa + (32'd1 << (IW + 2)), 1'b0, '0, 1'b0, 0, 0);
      check("R1 alias", last_h, 15);

      // R3: another branch with the same history uses the shared counter
      for (int i = 0; i < 4; i++) run_branch(pq, 1'b1, hit);
      step(pq, 1'b0, '0, 1'b0, 0, 0);
      check("R3 shared hist", last_h, 15);
      check("R3 shared ctr", last_c, 3);

      // R6: carried history/counter, not current state, drive the write
      step(32'h0000_0300, 1'b1, 32'h0000_0300, 1'b0, 15, 0);
      step(pa, 1'b0, '0, 1'b0, 0, 0);
      check("R6 ctr", last_c, 0);
      check("R6 taken", last_t, 0);
      step(32'h0000_0300, 1'b0, '0, 1'b0, 0, 0);
      check("R6 hist", last_h, 14);

      // R10: TTTN loop reaches full accuracy
      for (int i = 0; i < 60; i++) run_branch(pl, (i % 4) != 3, hit);
      miss = 0;
      for (int i = 0; i < 40; i++) begin
         run_branch(pl, (i % 4) != 3, hit);
         if (hit == 0) miss++;
      end
      check("R10 misses", miss, 0);

      // mixed traffic against the model
      for (int i = 0; i < 2000; i++)
         step($urandom, 1'($urandom), $urandom, 1'($urandom),
              int'($urandom % 16), int'($urandom % 4));

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule